// File: doc/BRIEF.md
# Serial Run-Length Violation Monitor

This block watches a recovered serial bit stream, one bit per enabled clock, and measures how many equal bits arrive back to back. When a run of ones or zeros grows past a programmable limit, the block raises a violation flag. Long runs starve a clock-recovery loop of transitions, so the flag is a link-health alarm.

The limit is set by a 5-bit code and a word-width selector. The selector sets the unit the code counts in: four bits for the 8 and 16 bit widths, five bits for the 10 and 20 bit widths. The flag has to be caught by logic clocked at the word rate, not the bit rate. The block therefore divides the bit enable by the word width to get a word tick, and holds the flag for a fixed number of word ticks. The flag is not tied to the word that holds the offending bits. It can rise before that word is assembled.

Top module: `run_length_monitor`

## Requirements
- R1: While `rst_n` is low and in the cycle after it is released, `viol_out` is 0. The run count, the word phase and the hold counter all start from empty.
- R2: Each accepted bit (`bit_en` = 1) that equals the previous accepted bit adds one to the run length. Any other accepted bit, including the first one after reset, sets the run length to 1. Runs of ones and runs of zeros are treated alike.
- R3: `width_sel` is coded 0 = 8 bits, 1 = 10 bits, 2 = 16 bits and 3 = 20 bits. For codes 0 and 2, the limit is (`thr_code` + 1) × 4 bits, which spans 4 to 128.
- R4: For codes 1 and 3, the limit is (`thr_code` + 1) × 5 bits, which spans 5 to 160.
- R5: A violation event happens on the accepted bit that makes the run length exactly one more than the limit. A run that continues past that point causes no further event.
- R6: The run length stops at 255 and does not wrap. A run of any length therefore gives exactly one event.
- R7: A word tick happens on the accepted bit that closes each group of W accepted bits, where W is the selected width. On the clock edge that takes in the event bit, `viol_out` goes to 1. It then stays at 1 until 4 word ticks (widths 8 and 10) or 3 word ticks (widths 16 and 20) have passed after the event.
- R8: An event that arrives while `viol_out` is still held restarts the full hold count.
- R9: When `bit_en` = 0, `bit_in` is ignored. The run length, the word phase and the hold count do not change.
- R10: When an event and a word tick fall on the same bit, the event wins: the hold count is reloaded in full and that tick does not count toward the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Accept `bit_in` on this clock |
| bit_in | input | 1 | Recovered serial data bit |
| width_sel | input | 2 | Word width: 0 = 8, 1 = 10, 2 = 16, 3 = 20 |
| thr_code | input | 5 | Limit code; the limit is (code + 1) × step |
| viol_out | output | 1 | Held violation flag |

## Verification
The interesting collision is an event landing on the same bit that closes a word. In that case the reload and the countdown both want the hold counter. The bench forces this case right after reset: it sends three alternating bits and then five ones with a limit of 4 in 8-bit mode, so the event bit is also the eighth bit. A correct design must then hold the flag for exactly 32 cycles, and both the per-cycle reference model and a direct cycle count check this. Back-to-back retriggers and random soak runs also produce events next to word ticks in every width.

// File: rtl/rlv_pkg.sv
package rlv_pkg;

    typedef enum logic [1:0] {
        WM_8  = 2'd0,
        WM_10 = 2'd1,
        WM_16 = 2'd2,
        WM_20 = 2'd3
    } wmode_e;

    localparam int PHASE_W = 5;

    // Bits per parallel word for a width mode
    function automatic logic [PHASE_W-1:0] word_bits(input wmode_e m);
        case (m)
            WM_8:    word_bits = PHASE_W'(8);
            WM_10:   word_bits = PHASE_W'(10);
            WM_16:   word_bits = PHASE_W'(16);
            default: word_bits = PHASE_W'(20);
        endcase
    endfunction

    // Threshold granularity: coded widths use five-bit steps
    function automatic logic [2:0] step_of(input wmode_e m);
        step_of = (m == WM_10 || m == WM_20) ? 3'd5 : 3'd4;
    endfunction

    function automatic logic is_wide(input wmode_e m);
        is_wide = (m == WM_16 || m == WM_20);
    endfunction

endpackage

// File: rtl/rlv_run_tracker.sv
module rlv_run_tracker
    import rlv_pkg::*;
#(
    parameter int RUN_W  = 8,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  wmode_e            mode,
    input  logic [CODE_W-1:0] thr_code,
    output logic [RUN_W-1:0]  run_len,
    output logic              last_bit,
    output logic              viol_evt
);
    localparam int THR_W = RUN_W + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    typedef struct packed {
        logic             seen;
        logic             last;
        logic [RUN_W-1:0] run;
    } trk_t;

    trk_t             s_d, s_q;
    logic [THR_W-1:0] limit;
    logic [RUN_W-1:0] run_next;
    logic             same;

    always_comb begin
        limit = THR_W'((THR_W'(thr_code) + THR_W'(1)) * THR_W'(step_of(mode)));
        same  = s_q.seen && (bit_in == s_q.last);
        if (!same)
            run_next = RUN_W'(1);
        else if (s_q.run == RUN_MAX)
            run_next = RUN_MAX;
        else
            run_next = s_q.run + RUN_W'(1);

        s_d      = s_q;
        viol_evt = 1'b0;
        if (bit_en) begin
            s_d.seen = 1'b1;
            s_d.last = bit_in;
            s_d.run  = run_next;
            viol_evt = ({1'b0, run_next} == (limit + THR_W'(1)));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign run_len  = s_q.run;
    assign last_bit = s_q.last;

endmodule

// File: rtl/rlv_word_phase.sv
module rlv_word_phase
    import rlv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  wmode_e             mode,
    output logic [PHASE_W-1:0] phase,
    output logic               word_tick
);
    typedef struct packed {
        logic [PHASE_W-1:0] ph;
    } ph_t;

    ph_t  s_d, s_q;
    logic last_slot;

    always_comb begin
        // >= keeps the phase in range if the width shrinks mid-stream
        last_slot = (s_q.ph >= (word_bits(mode) - PHASE_W'(1)));
        word_tick = bit_en && last_slot;
        s_d       = s_q;
        if (bit_en)
            s_d.ph = last_slot ? '0 : s_q.ph + PHASE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign phase = s_q.ph;

endmodule

// File: rtl/rlv_stretcher.sv
module rlv_stretcher
    import rlv_pkg::*;
#(
    parameter int HOLD_NARROW = 4,
    parameter int HOLD_WIDE   = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   viol_evt,
    input  logic   word_tick,
    input  wmode_e mode,
    output logic   hold_out
);
    localparam int HOLD_MAX = (HOLD_NARROW > HOLD_WIDE) ? HOLD_NARROW : HOLD_WIDE;
    localparam int CNT_W    = $clog2(HOLD_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } hold_t;

    hold_t            s_d, s_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        load_val = is_wide(mode) ? CNT_W'(HOLD_WIDE) : CNT_W'(HOLD_NARROW);
        s_d      = s_q;
        if (viol_evt)
            s_d.cnt = load_val;
        else if (word_tick && s_q.cnt != '0)
            s_d.cnt = s_q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign hold_out = (s_q.cnt != '0);

endmodule

// File: rtl/run_length_monitor.sv
module run_length_monitor
    import rlv_pkg::*;
#(
    parameter int RUN_W       = 8,
    parameter int CODE_W      = 5,
    parameter int HOLD_NARROW = 4,
    parameter int HOLD_WIDE   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic [1:0]        width_sel,
    input  logic [CODE_W-1:0] thr_code,
    output logic              viol_out
);
    wmode_e             mode;
    logic [RUN_W-1:0]   run_len;
    logic               last_bit;
    logic               viol_evt;
    logic [PHASE_W-1:0] word_phase;
    logic               word_tick;

    assign mode = wmode_e'(width_sel);

    rlv_run_tracker #(
        .RUN_W  (RUN_W),
        .CODE_W (CODE_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .mode     (mode),
        .thr_code (thr_code),
        .run_len  (run_len),
        .last_bit (last_bit),
        .viol_evt (viol_evt)
    );

    rlv_word_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .mode      (mode),
        .phase     (word_phase),
        .word_tick (word_tick)
    );

    rlv_stretcher #(
        .HOLD_NARROW (HOLD_NARROW),
        .HOLD_WIDE   (HOLD_WIDE)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .viol_evt  (viol_evt),
        .word_tick (word_tick),
        .mode      (mode),
        .hold_out  (viol_out)
    );

endmodule

// File: rtl/rlv_checker.sv
module rlv_checker
    import rlv_pkg::*;
#(
    parameter int RUN_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bit_en,
    input logic               bit_in,
    input logic [1:0]         width_sel,
    input logic [RUN_W-1:0]   run_len,
    input logic               last_bit,
    input logic               viol_evt,
    input logic [PHASE_W-1:0] word_phase,
    input logic               word_tick,
    input logic               viol_out
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    // R2: a differing accepted bit restarts the run at one
    p_run_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_in != last_bit) |=> (run_len == RUN_W'(1)));

    // R6: a saturated run stays saturated
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && run_len == RUN_MAX && bit_in == last_bit) |=> (run_len == RUN_MAX));

    // R5: events are never back to back
    p_single_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        viol_evt |=> !viol_evt);

    // R7: an event raises the flag on the next cycle
    p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        viol_evt |=> viol_out);

    // R7: the flag can only fall after a word tick
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_out && !word_tick) |=> viol_out);

    // R7: the flag can only rise after an event
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol_out && !viol_evt) |=> !viol_out);

    // R9: idle cycles change nothing
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(run_len) && $stable(word_phase)));

    // R7: the word phase stays below the word width
    p_phase_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(width_sel) == width_sel) |-> (word_phase < word_bits(wmode_e'(width_sel))));

endmodule

bind run_length_monitor rlv_checker #(.RUN_W(RUN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .bit_in     (bit_in),
    .width_sel  (width_sel),
    .run_len    (run_len),
    .last_bit   (last_bit),
    .viol_evt   (viol_evt),
    .word_phase (word_phase),
    .word_tick  (word_tick),
    .viol_out   (viol_out)
);

// File: tb/run_length_monitor_tb.sv
module run_length_monitor_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic [1:0] width_sel = 2'd0;
    logic [4:0] thr_code = 5'd0;
    logic       viol_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_req = "R1";

    // reference model state
    bit m_seen;
    bit m_last;
    int m_run;
    int m_phase;
    int m_hold;

    always #(CLK_PERIOD/2) clk = ~clk;

    run_length_monitor u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .width_sel (width_sel),
        .thr_code  (thr_code),
        .viol_out  (viol_out)
    );

    function automatic int width_of(input logic [1:0] w);
        case (w)
            2'd0: return 8;
            2'd1: return 10;
            2'd2: return 16;
            default: return 20;
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic en, input logic b);
        int limit;
        bit evt;
        bit tick;
        if (!en) return;
        limit = (int'(thr_code) + 1) * ((width_sel == 2'd1 || width_sel == 2'd3) ? 5 : 4);
        if (m_seen && b == m_last) m_run = (m_run >= 255) ? 255 : m_run + 1;
        else m_run = 1;
        m_seen = 1;
        m_last = b;
        evt  = (m_run == limit + 1);
        tick = (m_phase >= width_of(width_sel) - 1);
        m_phase = tick ? 0 : m_phase + 1;
        if (evt) m_hold = (width_sel >= 2'd2) ? 3 : 4;
        else if (tick && m_hold > 0) m_hold--;
    endtask

    // called just after a falling edge
    task automatic drive(input logic en, input logic b);
        bit_en = en;
        bit_in = b;
        @(posedge clk);
        model_step(en, b);
        @(negedge clk);
        check(cur_req, viol_out, m_hold != 0);
    endtask

    task automatic run_of(input logic b, input int len);
        for (int i = 0; i < len; i++) drive(1'b1, b);
    endtask

    task automatic do_reset(input logic [1:0] w, input logic [4:0] code);
        rst_n = 1'b0;
        bit_en = 1'b0;
        width_sel = w;
        thr_code = code;
        repeat (2) @(negedge clk);
        check("R1", viol_out, 1'b0);
        m_seen = 0; m_last = 0; m_run = 0; m_phase = 0; m_hold = 0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", viol_out, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int hi_cnt;
        @(negedge clk);

        // R3: 8-bit mode, code 3 -> limit 16
        cur_req = "R3";
        do_reset(2'd0, 5'd3);
        run_of(1'b1, 16);
        check("R3", viol_out, 1'b0);
        run_of(1'b1, 1);
        check("R3", viol_out, 1'b1);
        // R3: 16-bit mode, code 1 -> limit 8, zeros
        do_reset(2'd2, 5'd1);
        run_of(1'b1, 1);
        run_of(1'b0, 8);
        check("R3", viol_out, 1'b0);
        run_of(1'b0, 1);
        check("R3", viol_out, 1'b1);

        // R4: 10-bit mode code 2 -> 15; 20-bit code 31 -> 160
        cur_req = "R4";
        do_reset(2'd1, 5'd2);
        run_of(1'b0, 15);
        check("R4", viol_out, 1'b0);
        run_of(1'b0, 1);
        check("R4", viol_out, 1'b1);
        do_reset(2'd3, 5'd31);
        run_of(1'b1, 160);
        check("R4", viol_out, 1'b0);
        run_of(1'b1, 1);
        check("R4", viol_out, 1'b1);

        // R2: runs just under the limit never flag
        cur_req = "R2";
        do_reset(2'd0, 5'd1);
        for (int i = 0; i < 20; i++) run_of(i[0], 8);
        check("R2", viol_out, 1'b0);
        for (int i = 0; i < 40; i++) run_of(i[0], 1);

        // R5/R6: a 300-bit run gives one event, no wrap
        cur_req = "R6";
        do_reset(2'd0, 5'd0);
        run_of(1'b1, 300);
        check("R6", viol_out, 1'b0);

        // R8: back-to-back runs of 5 keep retriggering
        cur_req = "R8";
        do_reset(2'd0, 5'd0);
        for (int i = 0; i < 12; i++) run_of(i[0], 5);
        check("R8", viol_out, 1'b1);

        // R9: idle gaps with toggling data are ignored
        cur_req = "R9";
        do_reset(2'd1, 5'd0);
        for (int i = 0; i < 6; i++) begin
            drive(1'b1, 1'b1);
            drive(1'b0, 1'b0);
            drive(1'b0, 1'b1);
        end
        check("R9", viol_out, 1'b1);

        // R10 + R7: event on the word-closing bit, hold = 32 cycles
        cur_req = "R10";
        do_reset(2'd0, 5'd0);
        run_of(1'b0, 1);
        run_of(1'b1, 1);
        run_of(1'b0, 1);
        run_of(1'b1, 5);
        check("R10", viol_out, 1'b1);
        hi_cnt = 1;
        for (int i = 0; i < 40; i++) begin
            drive(1'b1, 1'b1);
            if (viol_out) hi_cnt++;
        end
        checks++;
        if (hi_cnt != 32) begin
            fails++;
            $display("FAIL R7 hold cycles actual=%0d expected=32", hi_cnt);
        end

        // R7: soak across all widths with random runs and gaps
        cur_req = "R7";
        for (int w = 0; w < 4; w++) begin
            do_reset(2'(w), 5'($urandom_range(0, 3)));
            for (int k = 0; k < 120; k++) begin
                int len = $urandom_range(1, 24);
                for (int j = 0; j < len; j++)
                    drive($urandom_range(0, 5) != 0, k[0]);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule